// File: doc/BRIEF.md
# Smart-Card Wait-Time and Guard Monitor

This block supervises the timing of a half-duplex smart-card link. It watches character-start strobes from the receive and transmit paths and counts elementary time units (ETU ticks) between them. Three protocol checks run side by side:

- The character gap check looks at the spacing between received characters.
- The block wait check covers the time from the last transmitted character to the first reply.
- The block guard check enforces the minimum spacing between a received character and the next transmitted one.

Two general-purpose timeout counters run next to these checks. Each one can count card-clock ticks, receive-clock ticks or ETU ticks, or be switched off.

Every check raises a sticky flag, and software clears a flag by writing 1 to its clear bit. A single interrupt line is the OR of all flags whose mask bit is 0. The serial datapath that produces the strobes is outside this block. All tick and strobe inputs are one-cycle enables in the system clock domain.

Top module: `sc_wait_guard_mon`

## Requirements
- R1: While reset is asserted, and after it is released, all flags read 0 and the interrupt is low.
- R2: With the character-gap enable high, an rx_start restarts the gap count from 0. The gap error flag (flags bit 0) sets on the ETU tick that brings the count past cwt_limit, that is, the (cwt_limit+1)-th tick. A new rx_start that arrives earlier restarts the count without an error.
- R3: With the character-gap enable low, no gap error is raised, and any measurement already in progress is dropped. Raising the enable again does not resume it until the next rx_start.
- R4: With blk_en high, tx_start starts the block-wait count and rx_start stops it. The block-wait flag (flags bit 1) sets on the (bwt_limit+1)-th ETU tick after tx_start if no rx_start came first.
- R5: With blk_en high, the ETU ticks from an rx_start to the next tx_start are counted. If that count is below bgt_limit at the tx_start, the guard flag (flags bit 2) sets. Only the first tx_start after each rx_start is judged.
- R6: With blk_en low, neither the block-wait flag nor the guard flag can set.
- R7: Each timeout counter n has a 2-bit source code: 0 = off, 1 = card_tick, 2 = rx_tick, 3 = etu_tick. Only ticks of the selected source advance the count.
- R8: Timeout flag n (flags bit 3+n) sets on the source tick that brings the count to gp_limit n. The count then holds, so further ticks raise nothing more. A limit of 0 never sets the flag.
- R9: Source code 0 clears the timeout count, so after it is re-enabled the full limit must be counted again.
- R10: Flags are sticky. A 1 on a flag_clr bit clears only that flag on the next edge. A flag that is set and cleared in the same cycle ends up set.
- R11: irq is high when any flag whose irq_mask bit is 0 is set. A mask bit of 1 blocks that flag from the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| etu_tick | input | 1 | One strobe per elementary time unit |
| card_tick | input | 1 | Card clock enable strobe |
| rx_tick | input | 1 | Receive clock enable strobe |
| rx_start | input | 1 | Leading edge of a received character |
| tx_start | input | 1 | Leading edge of a transmitted character |
| cwt_en | input | 1 | Character-gap check enable |
| cwt_limit | input | 16 | Maximum character gap in ETUs |
| blk_en | input | 1 | Enables both block-wait and guard checks |
| bwt_limit | input | 32 | Maximum block wait in ETUs |
| bgt_limit | input | 16 | Minimum guard spacing in ETUs |
| gp_sel | input | 2x2 | Source code per timeout counter |
| gp_limit | input | 2x16 | Timeout value per counter |
| flag_clr | input | 5 | Write-1 clear per flag |
| irq_mask | input | 5 | Per-flag interrupt mask, 1 = masked |
| flags | output | 5 | Sticky flags: gap, wait, guard, timeout 0, timeout 1 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:

- Every strobe lasts one clock cycle.
- rx_start and tx_start never come in the same cycle.
- Limits and source codes change only while the measurement they govern is idle or disabled.

The bench keeps to these rules. It drives at most one strobe per cycle, always on the falling edge. It reprograms a timeout counter only after a cycle with its source set to off, and it changes the protocol limits only between measurements.

// File: rtl/sc_mon_pkg.sv
package sc_mon_pkg;
    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_CARD = 2'd1,
        SRC_RX   = 2'd2,
        SRC_ETU  = 2'd3
    } clk_src_e;

    localparam int FLG_CWT     = 0;
    localparam int FLG_BWT     = 1;
    localparam int FLG_BGT     = 2;
    localparam int FLG_GP_BASE = 3;
endpackage

// File: rtl/sc_span_timer.sv
// Measures ETUs since a start event; raises expire when the limit is exceeded.
module sc_span_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start,
    input  logic         stop,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         expire
);
    typedef struct packed {
        logic         armed;
        logic [W-1:0] cnt;
    } st_t;

    st_t  s_d, s_q;
    logic hit;

    always_comb begin
        s_d = s_q;
        hit = s_q.armed && tick && (s_q.cnt == limit) && !start && !stop;
        if (!en) begin
            s_d.armed = 1'b0;
            s_d.cnt   = '0;
        end else if (start) begin
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
        end else if (stop || hit) begin
            s_d.armed = 1'b0;
        end else if (s_q.armed && tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    assign expire = hit && en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sc_guard_meter.sv
// Counts ETUs from a receive start to the next transmit start; flags short spacing.
module sc_guard_meter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         rx_start,
    input  logic         tx_start,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         too_short
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        too_short = en && s_q.valid && tx_start && (s_q.cnt < limit);
        if (!en) begin
            s_d = '0;
        end else if (rx_start) begin
            s_d.valid = 1'b1;
            s_d.cnt   = '0;
        end else begin
            if (tx_start) s_d.valid = 1'b0;
            if (tick && (s_q.cnt != '1)) s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sc_gp_timeout.sv
// Timeout counter with a selectable tick source; holds once the limit is reached.
module sc_gp_timeout
    import sc_mon_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         card_tick,
    input  logic         rx_tick,
    input  logic         etu_tick,
    input  logic [1:0]   sel,
    input  logic [W-1:0] limit,
    output logic         reached
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t          s_d, s_q;
    logic         src_tick;
    logic         step;
    logic [W-1:0] nxt;

    always_comb begin
        case (clk_src_e'(sel))
            SRC_CARD: src_tick = card_tick;
            SRC_RX:   src_tick = rx_tick;
            SRC_ETU:  src_tick = etu_tick;
            default:  src_tick = 1'b0;
        endcase
        nxt     = s_q.cnt + 1'b1;
        step    = src_tick && (s_q.cnt != limit);
        reached = step && (nxt == limit);
        s_d     = s_q;
        if (clk_src_e'(sel) == SRC_OFF) s_d.cnt = '0;
        else if (step)                  s_d.cnt = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sc_wait_guard_mon.sv
module sc_wait_guard_mon
    import sc_mon_pkg::*;
#(
    parameter  int CWT_W  = 16,
    parameter  int BWT_W  = 32,
    parameter  int BGT_W  = 16,
    parameter  int GP_W   = 16,
    parameter  int NUM_GP = 2,
    localparam int NFLG   = FLG_GP_BASE + NUM_GP
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        etu_tick,
    input  logic                        card_tick,
    input  logic                        rx_tick,
    input  logic                        rx_start,
    input  logic                        tx_start,
    input  logic                        cwt_en,
    input  logic [CWT_W-1:0]            cwt_limit,
    input  logic                        blk_en,
    input  logic [BWT_W-1:0]            bwt_limit,
    input  logic [BGT_W-1:0]            bgt_limit,
    input  logic [NUM_GP-1:0][1:0]      gp_sel,
    input  logic [NUM_GP-1:0][GP_W-1:0] gp_limit,
    input  logic [NFLG-1:0]             flag_clr,
    input  logic [NFLG-1:0]             irq_mask,
    output logic [NFLG-1:0]             flags,
    output logic                        irq
);
    typedef struct packed {
        logic [NFLG-1:0] flags;
    } st_t;

    st_t             s_d, s_q;
    logic            cwt_exp, bwt_exp, bgt_short;
    logic [NUM_GP-1:0] gp_hit;
    logic [NFLG-1:0] set_v;

    sc_span_timer #(.W(CWT_W)) u_cwt (
        .clk(clk), .rst_n(rst_n), .tick(etu_tick), .start(rx_start),
        .stop(1'b0), .en(cwt_en), .limit(cwt_limit), .expire(cwt_exp)
    );

    sc_span_timer #(.W(BWT_W)) u_bwt (
        .clk(clk), .rst_n(rst_n), .tick(etu_tick), .start(tx_start),
        .stop(rx_start), .en(blk_en), .limit(bwt_limit), .expire(bwt_exp)
    );

    sc_guard_meter #(.W(BGT_W)) u_bgt (
        .clk(clk), .rst_n(rst_n), .tick(etu_tick), .rx_start(rx_start),
        .tx_start(tx_start), .en(blk_en), .limit(bgt_limit), .too_short(bgt_short)
    );

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
        sc_gp_timeout #(.W(GP_W)) u_gp (
            .clk(clk), .rst_n(rst_n), .card_tick(card_tick), .rx_tick(rx_tick),
            .etu_tick(etu_tick), .sel(gp_sel[g]), .limit(gp_limit[g]),
            .reached(gp_hit[g])
        );
    end

    always_comb begin
        set_v                              = '0;
        set_v[FLG_CWT]                     = cwt_exp;
        set_v[FLG_BWT]                     = bwt_exp;
        set_v[FLG_BGT]                     = bgt_short;
        set_v[FLG_GP_BASE +: NUM_GP]       = gp_hit;
        s_d.flags = (s_q.flags & ~flag_clr) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags = s_q.flags;
    assign irq   = |(s_q.flags & ~irq_mask);
endmodule

// File: rtl/sc_wait_guard_mon_chk.sv
module sc_wait_guard_mon_chk
    import sc_mon_pkg::*;
#(
    parameter int NUM_GP = 2,
    parameter int NFLG   = FLG_GP_BASE + NUM_GP
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   etu_tick,
    input logic                   tx_start,
    input logic                   cwt_en,
    input logic                   blk_en,
    input logic [NUM_GP-1:0][1:0] gp_sel,
    input logic [NFLG-1:0]        flag_clr,
    input logic [NFLG-1:0]        irq_mask,
    input logic [NFLG-1:0]        flags,
    input logic                   irq
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (flags == '0));

    p_cwt_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_CWT]) |-> $past(etu_tick));

    p_cwt_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cwt_en |=> !$rose(flags[FLG_CWT]));

    p_bwt_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_BWT]) |-> $past(etu_tick));

    p_bgt_on_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_BGT]) |-> $past(tx_start));

    p_blk_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |=> (!$rose(flags[FLG_BWT]) && !$rose(flags[FLG_BGT])));

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp_chk
        p_gp_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (gp_sel[g] == 2'd0) |=> !$rose(flags[FLG_GP_BASE + g]));
    end

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

    p_all_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '1) |-> !irq);

    p_no_flag_no_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq);
endmodule

bind sc_wait_guard_mon sc_wait_guard_mon_chk #(.NUM_GP(NUM_GP)) u_chk (
    .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .tx_start(tx_start),
    .cwt_en(cwt_en), .blk_en(blk_en), .gp_sel(gp_sel), .flag_clr(flag_clr),
    .irq_mask(irq_mask), .flags(flags), .irq(irq)
);

// File: tb/sc_wait_guard_mon_tb.sv
module sc_wait_guard_mon_tb;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             etu_tick = 0, card_tick = 0, rx_tick = 0;
    logic             rx_start = 0, tx_start = 0;
    logic             cwt_en = 0, blk_en = 0;
    logic [15:0]      cwt_limit = 0, bgt_limit = 0;
    logic [31:0]      bwt_limit = 0;
    logic [1:0][1:0]  gp_sel = '0;
    logic [1:0][15:0] gp_limit = '0;
    logic [4:0]       flag_clr = '0, irq_mask = '0;
    logic [4:0]       flags;
    logic             irq;
    int               n_checks = 0, n_errors = 0;

    always #4 clk = ~clk;

    sc_wait_guard_mon u_dut (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .card_tick(card_tick),
        .rx_tick(rx_tick), .rx_start(rx_start), .tx_start(tx_start),
        .cwt_en(cwt_en), .cwt_limit(cwt_limit), .blk_en(blk_en),
        .bwt_limit(bwt_limit), .bgt_limit(bgt_limit), .gp_sel(gp_sel),
        .gp_limit(gp_limit), .flag_clr(flag_clr), .irq_mask(irq_mask),
        .flags(flags), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] lim;
        logic [7:0]  n_card;
        logic [7:0]  n_rx;
        logic [7:0]  n_etu;
        logic        exp;
    } vec_t;

    localparam vec_t GP_VECS [8] = '{
        '{2'd1, 16'd3, 8'd3, 8'd0, 8'd0, 1'b1},
        '{2'd1, 16'd3, 8'd2, 8'd5, 8'd5, 1'b0},
        '{2'd2, 16'd4, 8'd5, 8'd4, 8'd0, 1'b1},
        '{2'd2, 16'd4, 8'd0, 8'd3, 8'd9, 1'b0},
        '{2'd3, 16'd2, 8'd9, 8'd9, 8'd2, 1'b1},
        '{2'd3, 16'd5, 8'd0, 8'd0, 8'd4, 1'b0},
        '{2'd0, 16'd1, 8'd3, 8'd3, 8'd3, 1'b0},
        '{2'd1, 16'd0, 8'd4, 8'd0, 8'd0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic r, input logic t, input logic e, input logic c, input logic k);
        rx_start = r; tx_start = t; etu_tick = e; card_tick = c; rx_tick = k;
        @(negedge clk);
        rx_start = 0; tx_start = 0; etu_tick = 0; card_tick = 0; rx_tick = 0;
    endtask

    task automatic etus(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 0);
    endtask

    task automatic cards(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0);
    endtask

    task automatic clear_all();
        flag_clr = '1;
        cyc(0, 0, 0, 0, 0);
        flag_clr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 flags in reset", flags, 0);
        check("R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", flags, 0);

        // R7 R8: table walk over source selection and limits
        for (int v = 0; v < 8; v++) begin
            gp_sel[0] = GP_VECS[v].sel;
            gp_limit[0] = GP_VECS[v].lim;
            cards(int'(GP_VECS[v].n_card));
            for (int i = 0; i < int'(GP_VECS[v].n_rx); i++) cyc(0, 0, 0, 0, 1);
            etus(int'(GP_VECS[v].n_etu));
            check($sformatf("R7/R8 vector %0d timeout flag", v), flags[3], GP_VECS[v].exp);
            gp_sel[0] = 2'd0;
            clear_all();
        end

        // R2: gap error on (limit+1)-th tick
        cwt_en = 1; cwt_limit = 3;
        cyc(1, 0, 0, 0, 0);
        etus(3);
        check("R2 no gap error at limit", flags[0], 0);
        etus(1);
        check("R2 gap error past limit", flags[0], 1);
        clear_all();
        cyc(1, 0, 0, 0, 0);
        etus(2);
        cyc(1, 0, 0, 0, 0);
        etus(3);
        check("R2 restart by new character", flags[0], 0);
        etus(1);
        check("R2 error after restart", flags[0], 1);
        clear_all();

        // R3: disabled gap check
        cwt_en = 0;
        cyc(1, 0, 0, 0, 0);
        etus(10);
        check("R3 no gap error when disabled", flags[0], 0);
        cwt_en = 1;
        etus(10);
        check("R3 enable alone does not arm", flags[0], 0);
        cwt_en = 0;

        // R4: block wait
        blk_en = 1; bwt_limit = 5; bgt_limit = 0;
        cyc(0, 1, 0, 0, 0);
        etus(5);
        check("R4 no wait error at limit", flags[1], 0);
        etus(1);
        check("R4 wait error past limit", flags[1], 1);
        clear_all();
        cyc(0, 1, 0, 0, 0);
        etus(3);
        cyc(1, 0, 0, 0, 0);
        etus(10);
        check("R4 reply stops wait count", flags[1], 0);

        // R5: block guard
        bwt_limit = 1000; bgt_limit = 4;
        cyc(1, 0, 0, 0, 0);
        etus(3);
        cyc(0, 1, 0, 0, 0);
        check("R5 guard too short", flags[2], 1);
        clear_all();
        cyc(1, 0, 0, 0, 0);
        etus(4);
        cyc(0, 1, 0, 0, 0);
        check("R5 guard equal to limit ok", flags[2], 0);
        cyc(0, 1, 0, 0, 0);
        check("R5 second tx_start not judged", flags[2], 0);

        // R6: block checks disabled
        blk_en = 0; bwt_limit = 5;
        cyc(0, 1, 0, 0, 0);
        etus(10);
        check("R6 no wait error when disabled", flags[1], 0);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        check("R6 no guard error when disabled", flags[2], 0);
        clear_all();

        // R9: source off clears count
        gp_sel[1] = 2'd1; gp_limit[1] = 4;
        cards(3);
        gp_sel[1] = 2'd0;
        cyc(0, 0, 0, 0, 0);
        gp_sel[1] = 2'd1;
        cards(3);
        check("R9 count cleared by source off", flags[4], 0);
        cards(1);
        check("R9 flag at full limit", flags[4], 1);
        clear_all();
        cards(3);
        check("R8 count holds after reaching limit", flags[4], 0);
        gp_sel[1] = 2'd0;

        // R10: set wins over clear, per-bit clear
        cwt_en = 1; cwt_limit = 0;
        cyc(1, 0, 0, 0, 0);
        etus(1);
        cwt_en = 0;
        gp_sel[0] = 2'd1; gp_limit[0] = 1;
        flag_clr = 5'b01000;
        cyc(0, 0, 0, 1, 0);
        flag_clr = '0;
        check("R10 set wins over clear", flags, 5'b01001);
        flag_clr = 5'b01000;
        cyc(0, 0, 0, 0, 0);
        flag_clr = '0;
        check("R10 only selected flag cleared", flags, 5'b00001);
        cyc(0, 0, 0, 0, 0);
        check("R10 flag remains sticky", flags, 5'b00001);
        gp_sel[0] = 2'd0;

        // R11: interrupt masking
        irq_mask = 5'b00000;
        #1 check("R11 irq unmasked", irq, 1);
        irq_mask = 5'b00001;
        #1 check("R11 irq masked", irq, 0);
        irq_mask = 5'b11110;
        #1 check("R11 other masks do not block", irq, 1);
        clear_all();
        irq_mask = 5'b00000;
        #1 check("R11 no flags no irq", irq, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule